// File: doc/BRIEF.md
# USB Endpoint Mode Register Bank

This block holds the control and status settings of two non-control USB endpoints. It also holds the byte-wide data buffers of three endpoints. Firmware reaches it over a simple 8-bit register bus: an address, write data, a write strobe and a combinational read path. The serial interface engine (SIE) reaches it through a set of per-endpoint signals. The SIE reports ACK and NAK completions, pushes new 4-bit mode values, and reads back the stall, mode and NAK-interrupt-enable settings.

Each endpoint control register packs five fields into one byte: a stall request, a reserved bit, a NAK interrupt enable, an ACK-completion status flag and a 4-bit mode. The block treats the mode as an opaque code. The SIE applies stall to OUT traffic when the mode holds the ACK-OUT code and to IN traffic when the mode holds the ACK-IN code. Firmware keeps stall at 0 in every other mode. The block also settles same-cycle writes from the two sides, and it issues a one-cycle interrupt request per endpoint for each transaction that qualifies.

Top module: `usb_ep_cfg_bank`

## Requirements
- R1: After reset, both endpoint control registers (address 0x45 for endpoint 1, 0x46 for endpoint 2) read 0x00, ep_irq is 0, and sie_stall, sie_nak_ien and sie_mode are all 0.
- R2: Control register layout: bit 7 stall, bit 6 reserved, bit 5 NAK interrupt enable, bit 4 ACK status, bits 3:0 mode. A firmware write loads bits 7, 5 and 3:0. Bit 6 always reads 0, and firmware writes to bits 6 and 4 have no effect on their value.
- R3: sie_stall[i], sie_nak_ien[i] and sie_mode[4*i+3:4*i] always show the stall, NAK-enable and mode fields of control register i (i=0 at 0x45, i=1 at 0x46).
- R4: A pulse on sie_ack_done[i] sets the ACK status bit of register i at the next clock edge. A firmware write that register i accepts clears that bit, whatever the written value. If both happen in the same cycle, the bit ends up set.
- R5: A pulse on sie_nak_done[i] raises ep_irq[i] in the following cycle only when the NAK interrupt enable of register i is 1. Otherwise it causes no interrupt.
- R6: If sie_mode_we[i] and a firmware write to register i fall in the same cycle, the SIE mode value is stored. The whole firmware write is discarded: stall, NAK enable and the ACK status bit are left unchanged.
- R7: A pulse on sie_ack_done[i] raises ep_irq[i] for exactly one cycle, in the cycle after the pulse.
- R8: An SIE mode update replaces only bits 3:0 of register i. Stall and NAK enable keep their values, and an ACK completion in the same cycle still sets the ACK status bit.
- R9: An SIE mode update on one endpoint does not block a same-cycle firmware write to the other endpoint's register. Both writes take effect.
- R10: Each data buffer holds eight bytes: endpoint 0 at 0x50-0x57, endpoint 1 at 0x58-0x5F and endpoint 2 at 0x60-0x67. A firmware write stores a byte that later reads back from the same address, and each buffer is independent of the others.
- R11: Reads from any address outside 0x45-0x46 and 0x50-0x67 return 0x00. Writes to such addresses change no register or buffer byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_addr | input | 8 | Firmware register address |
| fw_wdata | input | 8 | Firmware write data |
| fw_we | input | 1 | Firmware write strobe |
| fw_rdata | output | 8 | Firmware read data for fw_addr (combinational) |
| sie_mode_we | input | 2 | Per-endpoint SIE mode update strobe |
| sie_mode_val | input | 8 | New mode values, 4 bits per endpoint |
| sie_ack_done | input | 2 | Per-endpoint pulse: transaction completed with ACK |
| sie_nak_done | input | 2 | Per-endpoint pulse: transaction completed with NAK |
| sie_stall | output | 2 | Stall field per endpoint |
| sie_mode | output | 8 | Mode field per endpoint, 4 bits each |
| sie_nak_ien | output | 2 | NAK interrupt enable per endpoint |
| ep_irq | output | 2 | One-cycle endpoint interrupt request per endpoint |

## Verification
The hardest cases to reach are the same-cycle collisions. One is an SIE mode update landing on the very register that firmware is writing. The other is an SIE update to one endpoint while firmware writes the other. A bench that issues one bus operation per cycle never produces either case. The stimulus tasks therefore only set strobes, and a separate step advances the clock, so firmware and SIE strobes can be raised together before one edge. The bench first sets the ACK status bit through an ACK completion, so that the discarded firmware write can be seen as a status bit that stayed set. The cross-endpoint case is read back from both registers afterwards.

// File: rtl/usb_ep_cfg_pkg.sv
package usb_ep_cfg_pkg;

   localparam int MODE_W = 4;

   // Field order is fixed: firmware and the SIE decode these positions.
   typedef struct packed {
      logic              stall;
      logic              rsvd;
      logic              nak_ien;
      logic              acked;
      logic [MODE_W-1:0] mode;
   } ep_mode_t;

   localparam int CTRL_W = $bits(ep_mode_t);

endpackage

// File: rtl/ep_mode_reg.sv
module ep_mode_reg
   import usb_ep_cfg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fw_sel,
   input  logic [CTRL_W-1:0] fw_wdata,
   input  logic              sie_we,
   input  logic [MODE_W-1:0] sie_mode,
   input  logic              ack_done,
   input  logic              nak_done,
   output ep_mode_t          q,
   output logic              irq
);

   ep_mode_t fw_view;
   logic     fw_take;

   assign fw_view = ep_mode_t'(fw_wdata);
   // the SIE owns the register in a collision cycle
   assign fw_take = fw_sel && !sie_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q   <= '0;
         irq <= 1'b0;
      end else begin
         irq <= ack_done || (nak_done && q.nak_ien);
         q.rsvd <= 1'b0;
         if (sie_we) begin
            q.mode <= sie_mode;
         end else if (fw_take) begin
            q.stall   <= fw_view.stall;
            q.nak_ien <= fw_view.nak_ien;
            q.mode    <= fw_view.mode;
         end
         if (ack_done) begin
            q.acked <= 1'b1;
         end else if (fw_take) begin
            q.acked <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ep_data_buf.sv
module ep_data_buf #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] idx,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   // contents are undefined until written; no reset on purpose
   always_ff @(posedge clk) begin
      if (we) begin
         mem[idx] <= wdata;
      end
   end

   assign rdata = mem[idx];

endmodule

// File: rtl/usb_ep_cfg_bank.sv
module usb_ep_cfg_bank
   import usb_ep_cfg_pkg::*;
#(
   parameter int               ADDR_W      = 8,
   parameter int               DATA_W      = 8,
   parameter int               NUM_MODE_EP = 2,
   parameter int               NUM_BUF_EP  = 3,
   parameter int               BUF_DEPTH   = 8,
   parameter logic [ADDR_W-1:0] MODE_BASE  = 8'h45,
   parameter logic [ADDR_W-1:0] BUF_BASE   = 8'h50
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             fw_addr,
   input  logic [DATA_W-1:0]             fw_wdata,
   input  logic                          fw_we,
   output logic [DATA_W-1:0]             fw_rdata,
   input  logic [NUM_MODE_EP-1:0]        sie_mode_we,
   input  logic [NUM_MODE_EP*MODE_W-1:0] sie_mode_val,
   input  logic [NUM_MODE_EP-1:0]        sie_ack_done,
   input  logic [NUM_MODE_EP-1:0]        sie_nak_done,
   output logic [NUM_MODE_EP-1:0]        sie_stall,
   output logic [NUM_MODE_EP*MODE_W-1:0] sie_mode,
   output logic [NUM_MODE_EP-1:0]        sie_nak_ien,
   output logic [NUM_MODE_EP-1:0]        ep_irq
);

   localparam int IDX_W    = $clog2(BUF_DEPTH);
   localparam int SEL_W    = ADDR_W - IDX_W;
   localparam int BUF_SPAN = NUM_BUF_EP * BUF_DEPTH;

   // elaboration-time parameter checks
   if (DATA_W != CTRL_W) begin : g_bad_width
      $error("DATA_W must equal the control register width");
   end
   if (BUF_DEPTH < 2 || (BUF_DEPTH & (BUF_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("BUF_DEPTH must be a power of two of at least 2");
   end
   if (int'(MODE_BASE) + NUM_MODE_EP > int'(BUF_BASE)) begin : g_bad_map
      $error("control registers overlap the buffer window");
   end
   if (int'(BUF_BASE) + BUF_SPAN > 2 ** ADDR_W) begin : g_bad_span
      $error("buffer window exceeds the address space");
   end

   // address decode
   logic [ADDR_W-1:0]      buf_off;
   logic                   buf_hit;
   logic [SEL_W-1:0]       buf_sel;
   logic [IDX_W-1:0]       buf_idx;
   logic [NUM_MODE_EP-1:0] mode_hit;

   assign buf_off = fw_addr - BUF_BASE;
   assign buf_hit = (fw_addr >= BUF_BASE) &&
                    ({1'b0, buf_off} < (ADDR_W + 1)'(BUF_SPAN));
   assign buf_sel = buf_off[ADDR_W-1:IDX_W];
   assign buf_idx = buf_off[IDX_W-1:0];

   // endpoint control registers, each with its own update strobe
   ep_mode_t                      mode_q [NUM_MODE_EP];
   logic [NUM_MODE_EP*DATA_W-1:0] mode_q_flat;

   for (genvar i = 0; i < NUM_MODE_EP; i++) begin : g_mode
      localparam logic [ADDR_W-1:0] MY_ADDR = MODE_BASE + ADDR_W'(i);

      assign mode_hit[i] = (fw_addr == MY_ADDR);

      ep_mode_reg u_mode (
         .clk      (clk),
         .rst_n    (rst_n),
         .fw_sel   (fw_we && mode_hit[i]),
         .fw_wdata (fw_wdata),
         .sie_we   (sie_mode_we[i]),
         .sie_mode (sie_mode_val[i*MODE_W +: MODE_W]),
         .ack_done (sie_ack_done[i]),
         .nak_done (sie_nak_done[i]),
         .q        (mode_q[i]),
         .irq      (ep_irq[i])
      );

      assign mode_q_flat[i*DATA_W +: DATA_W]   = mode_q[i];
      assign sie_stall[i]                      = mode_q[i].stall;
      assign sie_nak_ien[i]                    = mode_q[i].nak_ien;
      assign sie_mode[i*MODE_W +: MODE_W]      = mode_q[i].mode;
   end

   // endpoint data buffers
   logic [DATA_W-1:0] buf_rd [NUM_BUF_EP];

   for (genvar j = 0; j < NUM_BUF_EP; j++) begin : g_buf
      ep_data_buf #(
         .DEPTH  (BUF_DEPTH),
         .DATA_W (DATA_W)
      ) u_buf (
         .clk   (clk),
         .we    (fw_we && buf_hit && (buf_sel == SEL_W'(j))),
         .idx   (buf_idx),
         .wdata (fw_wdata),
         .rdata (buf_rd[j])
      );
   end

   // read mux: unmapped addresses fall through to zero
   always_comb begin
      fw_rdata = '0;
      for (int i = 0; i < NUM_MODE_EP; i++) begin
         if (mode_hit[i]) begin
            fw_rdata = mode_q_flat[i*DATA_W +: DATA_W];
         end
      end
      if (buf_hit) begin
         for (int j = 0; j < NUM_BUF_EP; j++) begin
            if (buf_sel == SEL_W'(j)) begin
               fw_rdata = buf_rd[j];
            end
         end
      end
   end

endmodule

// File: rtl/usb_ep_cfg_chk.sv
module usb_ep_cfg_chk #(
   parameter int                ADDR_W      = 8,
   parameter int                DATA_W      = 8,
   parameter int                NUM_MODE_EP = 2,
   parameter int                NUM_BUF_EP  = 3,
   parameter int                BUF_DEPTH   = 8,
   parameter int                MODE_W      = 4,
   parameter logic [ADDR_W-1:0] MODE_BASE   = 8'h45,
   parameter logic [ADDR_W-1:0] BUF_BASE    = 8'h50
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [ADDR_W-1:0]             fw_addr,
   input logic                          fw_we,
   input logic [DATA_W-1:0]             fw_rdata,
   input logic [NUM_MODE_EP-1:0]        sie_mode_we,
   input logic [NUM_MODE_EP*MODE_W-1:0] sie_mode_val,
   input logic [NUM_MODE_EP-1:0]        sie_ack_done,
   input logic [NUM_MODE_EP-1:0]        sie_nak_done,
   input logic [NUM_MODE_EP-1:0]        ep_irq,
   input logic [NUM_MODE_EP*DATA_W-1:0] mode_q_flat
);

   int  a_now;
   logic mapped;

   always_comb begin
      a_now  = int'(fw_addr);
      mapped = (a_now >= int'(MODE_BASE) && a_now < int'(MODE_BASE) + NUM_MODE_EP) ||
               (a_now >= int'(BUF_BASE) && a_now < int'(BUF_BASE) + NUM_BUF_EP * BUF_DEPTH);
   end

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> fw_rdata == '0); // R11

   for (genvar i = 0; i < NUM_MODE_EP; i++) begin : g_ep
      localparam int B = i * DATA_W;
      logic fw_hit;
      assign fw_hit = fw_we && (a_now == int'(MODE_BASE) + i);

      AST_ACK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         sie_ack_done[i] |=> mode_q_flat[B+4]); // R4

      AST_FW_CLEARS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
         fw_hit && !sie_mode_we[i] && !sie_ack_done[i] |=> !mode_q_flat[B+4]); // R4

      AST_SIE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         sie_mode_we[i] |=> mode_q_flat[B +: MODE_W] == $past(sie_mode_val[i*MODE_W +: MODE_W])); // R6

      AST_SIE_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
         sie_mode_we[i] |=> $stable(mode_q_flat[B+7]) && $stable(mode_q_flat[B+5])); // R8

      AST_NAK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         sie_nak_done[i] && !mode_q_flat[B+5] && !sie_ack_done[i] |=> !ep_irq[i]); // R5

      AST_ACK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
         sie_ack_done[i] |=> ep_irq[i]); // R7

      AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ep_irq[i]) |-> $past(sie_ack_done[i] || sie_nak_done[i])); // R7
   end

endmodule

bind usb_ep_cfg_bank usb_ep_cfg_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .NUM_MODE_EP (NUM_MODE_EP),
   .NUM_BUF_EP  (NUM_BUF_EP),
   .BUF_DEPTH   (BUF_DEPTH),
   .MODE_W      (usb_ep_cfg_pkg::MODE_W),
   .MODE_BASE   (MODE_BASE),
   .BUF_BASE    (BUF_BASE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fw_addr      (fw_addr),
   .fw_we        (fw_we),
   .fw_rdata     (fw_rdata),
   .sie_mode_we  (sie_mode_we),
   .sie_mode_val (sie_mode_val),
   .sie_ack_done (sie_ack_done),
   .sie_nak_done (sie_nak_done),
   .ep_irq       (ep_irq),
   .mode_q_flat  (mode_q_flat)
);

// File: tb/sim_usb_ep_cfg_bank.sv
`timescale 1ns/1ps
module sim_usb_ep_cfg_bank;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] fw_addr = '0;
   logic [7:0] fw_wdata = '0;
   logic       fw_we = 1'b0;
   logic [7:0] fw_rdata;
   logic [1:0] sie_mode_we = '0;
   logic [7:0] sie_mode_val = '0;
   logic [1:0] sie_ack_done = '0;
   logic [1:0] sie_nak_done = '0;
   logic [1:0] sie_stall;
   logic [7:0] sie_mode;
   logic [1:0] sie_nak_ien;
   logic [1:0] ep_irq;

   always #4 clk = ~clk;   // 125 MHz

   usb_ep_cfg_bank u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .fw_addr      (fw_addr),
      .fw_wdata     (fw_wdata),
      .fw_we        (fw_we),
      .fw_rdata     (fw_rdata),
      .sie_mode_we  (sie_mode_we),
      .sie_mode_val (sie_mode_val),
      .sie_ack_done (sie_ack_done),
      .sie_nak_done (sie_nak_done),
      .sie_stall    (sie_stall),
      .sie_mode     (sie_mode),
      .sie_nak_ien  (sie_nak_ien),
      .ep_irq       (ep_irq)
   );

   // observation kinds
   localparam int K_RD   = 0;
   localparam int K_IRQ  = 1;
   localparam int K_MODE = 2;
   localparam int K_CTRL = 3;

   typedef struct {
      int         kind;
      logic [7:0] exp;
      string      req;
   } item_t;

   item_t sb [$];
   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done     = 1'b0;

   function automatic logic [7:0] observe(int kind);
      case (kind)
         K_RD:    return fw_rdata;
         K_IRQ:   return {6'b0, ep_irq};
         K_MODE:  return sie_mode;
         default: return {4'b0, sie_stall, sie_nak_ien};
      endcase
   endfunction

   // monitor: compares every queued expectation mid-cycle
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it  = sb.pop_front();
         act = observe(it.kind);
         n_checks++;
         if (act !== it.exp) begin
            n_fails++;
            $display("FAIL %s (kind %0d): actual %02h expected %02h",
                     it.req, it.kind, act, it.exp);
         end
      end
   end

   task automatic expect_val(int kind, logic [7:0] exp, string req);
      item_t it;
      it.kind = kind;
      it.exp  = exp;
      it.req  = req;
      sb.push_back(it);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      fw_we        = 1'b0;
      sie_mode_we  = '0;
      sie_ack_done = '0;
      sie_nak_done = '0;
   endtask

   task automatic set_wr(logic [7:0] a, logic [7:0] d);
      fw_addr  = a;
      fw_wdata = d;
      fw_we    = 1'b1;
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      set_wr(a, d);
      step();
   endtask

   task automatic rd(logic [7:0] a, logic [7:0] e, string req);
      fw_addr = a;
      expect_val(K_RD, e, req);
      step();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1 reset state
      expect_val(K_IRQ, 8'h00, "R1 irq");
      expect_val(K_MODE, 8'h00, "R1 sie_mode");
      expect_val(K_CTRL, 8'h00, "R1 stall/nak");
      rd(8'h45, 8'h00, "R1 ep1 reg");
      rd(8'h46, 8'h00, "R1 ep2 reg");

      // R2 layout, reserved and status bits ignore firmware
      wr(8'h45, 8'hFF);
      rd(8'h45, 8'hAF, "R2 ep1 all ones");
      wr(8'h46, 8'h5A);
      rd(8'h46, 8'h0A, "R2 ep2 rsvd/ack ignored");

      // R3 SIE-side view
      expect_val(K_MODE, 8'hAF, "R3 sie_mode");
      expect_val(K_CTRL, 8'h05, "R3 stall/nak");
      step();

      // R4 / R7 ACK completion on ep2
      sie_ack_done = 2'b10;
      step();
      expect_val(K_IRQ, 8'h02, "R7 ack irq");
      rd(8'h46, 8'h1A, "R4 ack set");
      expect_val(K_IRQ, 8'h00, "R7 single cycle");
      rd(8'h46, 8'h1A, "R4 ack holds");
      wr(8'h46, 8'h0A);
      rd(8'h46, 8'h0A, "R4 fw write clears ack");

      // R4 ack set and firmware write in the same cycle
      set_wr(8'h46, 8'h03);
      sie_ack_done = 2'b10;
      step();
      expect_val(K_IRQ, 8'h02, "R7 ack irq with write");
      rd(8'h46, 8'h13, "R4 set wins over clear");

      // R5 NAK completions
      sie_nak_done = 2'b01;
      step();
      expect_val(K_IRQ, 8'h01, "R5 nak enabled");
      step();
      sie_nak_done = 2'b10;
      step();
      expect_val(K_IRQ, 8'h00, "R5 nak masked");
      step();

      // R6 SIE wins a same-register collision
      sie_ack_done = 2'b01;
      step();
      set_wr(8'h45, 8'h00);
      sie_mode_we  = 2'b01;
      sie_mode_val = 8'h06;
      step();
      rd(8'h45, 8'hB6, "R6 fw write discarded");

      // R8 SIE update with ACK keeps firmware fields
      wr(8'h46, 8'h80);
      rd(8'h46, 8'h80, "R8 setup");
      sie_mode_we  = 2'b10;
      sie_mode_val = 8'hC0;
      sie_ack_done = 2'b10;
      step();
      rd(8'h46, 8'h9C, "R8 mode only plus ack");

      // R9 cross-endpoint writes both land
      set_wr(8'h46, 8'h21);
      sie_mode_we  = 2'b01;
      sie_mode_val = 8'h02;
      step();
      rd(8'h45, 8'hB2, "R9 sie update ep1");
      rd(8'h46, 8'h21, "R9 fw write ep2");

      // R10 buffers
      wr(8'h50, 8'h11);
      wr(8'h57, 8'h22);
      wr(8'h58, 8'h33);
      wr(8'h5F, 8'h44);
      wr(8'h60, 8'h55);
      wr(8'h67, 8'h66);
      rd(8'h50, 8'h11, "R10 ep0 first");
      rd(8'h57, 8'h22, "R10 ep0 last");
      rd(8'h58, 8'h33, "R10 ep1 first");
      rd(8'h5F, 8'h44, "R10 ep1 last");
      rd(8'h60, 8'h55, "R10 ep2 first");
      rd(8'h67, 8'h66, "R10 ep2 last");

      // R11 unmapped addresses
      rd(8'h44, 8'h00, "R11 below regs");
      rd(8'h47, 8'h00, "R11 above regs");
      rd(8'h4F, 8'h00, "R11 below bufs");
      rd(8'h68, 8'h00, "R11 above bufs");
      rd(8'hFF, 8'h00, "R11 top");
      wr(8'h47, 8'hFF);
      wr(8'h68, 8'hFF);
      rd(8'h45, 8'hB2, "R11 ep1 untouched");
      rd(8'h46, 8'h21, "R11 ep2 untouched");
      rd(8'h67, 8'h66, "R11 buffer untouched");

      step();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule